// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address. It walks a two-level page table held in memory, with 4 KiB pages and 4-byte entries. A request supplies the virtual address, the root table page number, the privilege (supervisor or user), the two permission-relaxing controls, and the access kind (load, store or fetch). The walker then reads table entries through a simple single-outstanding memory port. At each entry it decides whether the entry is malformed, points to a further table, or is a leaf. It checks the leaf's permissions and superpage alignment. Where the leaf still needs its accessed flag set, or its dirty flag set for a store, it updates the entry with an atomic compare-and-write.

The walk ends with a one-cycle done pulse. The pulse carries either a physical address or a fault code, and echoes the access kind that was requested. Protection and attribute checking happens outside the block. That result arrives as an error bit with each memory response and turns the walk into an access fault.

Top module: `vm_walker`

## Requirements
- R1: After reset `req_ready`=1, `done`=0 and `mem_req_valid`=0. A request is accepted only while `req_ready`=1, and `req_ready` stays 0 until the walk finishes. Any change of `req_valid` or request fields during a walk has no effect on its result.
- R2: Entry layout is V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, A bit 6, D bit 7, and PPN in bits 31:10 (upper part 31:20, lower part 19:10). The first read goes to root×4096 + VA[31:22]×4. A second-level read goes to pointer.PPN×4096 + VA[21:12]×4.
- R3: An entry with V=0, or with R=0 and W=1, ends the walk with a page fault.
- R4: An entry with V=1, R=0 and X=0 is a pointer. A pointer found in the second-level table gives a page fault.
- R5: An error on any table read or compare-and-write gives an access fault, never a page fault.
- R6: For a leaf, a load needs R, or X when MXR=1. A store needs W. A fetch needs X, whatever MXR is. In user mode U must be 1. In supervisor mode a U=1 leaf is allowed only for loads and stores with SUM=1. A failed check gives a page fault.
- R7: A first-level leaf whose PPN bits 19:10 are non-zero gives a page fault.
- R8: A permitted leaf with A=0, or a store to a leaf with D=0, issues a compare-and-write whose compare value is the entry as read. Its write value is that entry with A set, and D set too for a store. No other leaf issues a write.
- R9: When the compare-and-write reports a mismatch, the walker re-reads the same entry address at the same level and decides again.
- R10: On success, PA[11:0]=VA[11:0] and PA[33:22]=PTE[31:20]. PA[21:12] is VA[21:12] for a first-level leaf and PTE[19:10] otherwise.
- R11: `done` is high for exactly one cycle per walk. `fault` is 0 for none, 1 for page fault and 2 for access fault. `fault_acc` returns the access kind (0 load, 1 store, 2 fetch).
- R12: `mem_req_valid` is a one-cycle pulse, and no new request is issued before the response to the previous one. A walk issues exactly the reads and writes the rules above call for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when ready) |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 32 | Virtual address |
| req_root_ppn | input | 22 | Root table page number |
| req_priv_s | input | 1 | 1 = supervisor, 0 = user |
| req_sum | input | 1 | Supervisor may load/store user pages |
| req_mxr | input | 1 | Execute-only pages readable by loads |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_write | output | 1 | 1 = compare-and-write, 0 = read |
| mem_req_addr | output | 34 | Entry byte address |
| mem_req_cmp | output | 32 | Compare value for compare-and-write |
| mem_req_wdata | output | 32 | Write value for compare-and-write |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Access check failed |
| mem_rsp_match | input | 1 | Compare-and-write found the expected value and wrote |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 2 | Result code |
| fault_acc | output | 2 | Access kind of the finished walk |
| paddr | output | 34 | Physical address on success |

## Verification
The assertions watch, on every cycle, properties that do not depend on table contents. Done and memory request strobes are single-cycle pulses. A busy walker refuses new work. An access fault always follows an errored response. A compare-and-write changes nothing but the A and D flags. A successful translation keeps the page offset. The outcome of each walk can only be shown by the bench's scenarios: which rule fires, the addresses read, the updated entry in memory, the retry after an interfering write, and the assembled physical address. These scenarios sweep every flag combination of the entry against every privilege, control and access combination at both levels.

// File: rtl/pagewalk_pkg.sv
package pagewalk_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_PAGE   = 2'd1,
    FLT_ACCESS = 2'd2
  } flt_e;

  // flag positions inside a table entry
  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;
endpackage

// File: rtl/vm_walker_pte_check.sv
module vm_walker_pte_check
  import pagewalk_pkg::*;
#(
  parameter int PTE_W   = 32,
  parameter int VPN_W   = 10,
  parameter int PPN_LSB = 10
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             level,
  input  logic             priv_s,
  input  logic             sum,
  input  logic             mxr,
  input  logic [1:0]       acc,
  output logic             bad_enc,
  output logic             is_ptr,
  output logic             leaf_fault,
  output logic             need_upd,
  output logic [PTE_W-1:0] upd_pte
);
  logic v, r, w, x, u, a, d;
  logic rwx_ok, mode_ok, misal, is_store;

  always_comb begin
    v = pte[BIT_V];
    r = pte[BIT_R];
    w = pte[BIT_W];
    x = pte[BIT_X];
    u = pte[BIT_U];
    a = pte[BIT_A];
    d = pte[BIT_D];
    is_store = (acc == ACC_STORE);

    // reserved write-only encoding or invalid entry
    bad_enc = !v || (!r && w);
    is_ptr  = !bad_enc && !r && !x;

    case (acc)
      ACC_LOAD:  rwx_ok = r | (mxr & x);
      ACC_STORE: rwx_ok = w;
      ACC_FETCH: rwx_ok = x;
      default:   rwx_ok = 1'b0;
    endcase

    if (!priv_s)  mode_ok = u;
    else if (u)   mode_ok = sum && (acc != ACC_FETCH);
    else          mode_ok = 1'b1;

    misal      = level && (pte[PPN_LSB +: VPN_W] != '0);
    leaf_fault = !rwx_ok || !mode_ok || misal;
    need_upd   = !a || (is_store && !d);

    upd_pte        = pte;
    upd_pte[BIT_A] = 1'b1;
    if (is_store) upd_pte[BIT_D] = 1'b1;
  end
endmodule

// File: rtl/vm_walker_addr.sv
module vm_walker_addr #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int VPN_W   = 10,
  parameter int PA_W    = 34,
  parameter int PTE_W   = 32,
  parameter int PPN_LSB = 10
) (
  input  logic [VA_W-1:0]        va,
  input  logic [PA_W-OFF_W-1:0]  base,
  input  logic                   level,
  input  logic [PTE_W-1:0]       leaf_pte,
  output logic [PA_W-1:0]        entry_addr,
  output logic [PA_W-1:0]        phys_addr
);
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int IDX_SH = $clog2(PTE_W / 8);

  logic [VPN_W-1:0] vpn_sel;
  logic [PPN_W-1:0] leaf_ppn;
  logic [VPN_W-1:0] low_ppn;

  always_comb begin
    vpn_sel    = level ? va[OFF_W+VPN_W +: VPN_W] : va[OFF_W +: VPN_W];
    entry_addr = {base, {OFF_W{1'b0}}} + (PA_W'(vpn_sel) << IDX_SH);
    leaf_ppn   = leaf_pte[PPN_LSB +: PPN_W];
    // superpage: low page-number part comes from the virtual address
    low_ppn    = level ? va[OFF_W +: VPN_W] : leaf_ppn[VPN_W-1:0];
    phys_addr  = {leaf_ppn[PPN_W-1:VPN_W], low_ppn, va[OFF_W-1:0]};
  end
endmodule

// File: rtl/vm_walker.sv
module vm_walker
  import pagewalk_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int VPN_W   = 10,
  parameter int PA_W    = 34,
  parameter int PTE_W   = 32,
  parameter int PPN_LSB = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [PA_W-OFF_W-1:0] req_root_ppn,
  input  logic                  req_priv_s,
  input  logic                  req_sum,
  input  logic                  req_mxr,
  input  logic [1:0]            req_acc,
  output logic                  mem_req_valid,
  output logic                  mem_req_write,
  output logic [PA_W-1:0]       mem_req_addr,
  output logic [PTE_W-1:0]      mem_req_cmp,
  output logic [PTE_W-1:0]      mem_req_wdata,
  input  logic                  mem_rsp_valid,
  input  logic [PTE_W-1:0]      mem_rsp_data,
  input  logic                  mem_rsp_err,
  input  logic                  mem_rsp_match,
  output logic                  done,
  output logic [1:0]            fault,
  output logic [1:0]            fault_acc,
  output logic [PA_W-1:0]       paddr
);
  localparam int PPN_W = PA_W - OFF_W;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RWAIT, S_CAS, S_CWAIT} st_e;

  st_e              st, nxt;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             priv_q, sum_q, mxr_q;
  logic [PPN_W-1:0] base_q;
  logic             lvl_q;
  logic [PTE_W-1:0] pte_q, upd_q;

  logic             bad_enc, is_ptr, leaf_fault, need_upd;
  logic [PTE_W-1:0] chk_upd, leaf_src;
  logic [PA_W-1:0]  entry_addr, phys_addr;
  logic             fin, go_down;
  flt_e             fin_code;

  vm_walker_pte_check #(.PTE_W(PTE_W), .VPN_W(VPN_W), .PPN_LSB(PPN_LSB)) u_chk (
    .pte(mem_rsp_data), .level(lvl_q), .priv_s(priv_q), .sum(sum_q), .mxr(mxr_q),
    .acc(acc_q), .bad_enc(bad_enc), .is_ptr(is_ptr), .leaf_fault(leaf_fault),
    .need_upd(need_upd), .upd_pte(chk_upd)
  );

  assign leaf_src = (st == S_CWAIT) ? pte_q : mem_rsp_data;

  vm_walker_addr #(.VA_W(VA_W), .OFF_W(OFF_W), .VPN_W(VPN_W), .PA_W(PA_W),
                   .PTE_W(PTE_W), .PPN_LSB(PPN_LSB)) u_addr (
    .va(va_q), .base(base_q), .level(lvl_q), .leaf_pte(leaf_src),
    .entry_addr(entry_addr), .phys_addr(phys_addr)
  );

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD) || (st == S_CAS);
  assign mem_req_write = (st == S_CAS);
  assign mem_req_addr  = entry_addr;
  assign mem_req_cmp   = pte_q;
  assign mem_req_wdata = upd_q;

  always_comb begin
    nxt      = st;
    fin      = 1'b0;
    fin_code = FLT_NONE;
    go_down  = 1'b0;
    case (st)
      S_IDLE: if (req_valid) nxt = S_RD;
      S_RD:   nxt = S_RWAIT;
      S_CAS:  nxt = S_CWAIT;
      S_RWAIT: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          fin = 1'b1; fin_code = FLT_ACCESS;
        end else if (bad_enc) begin
          fin = 1'b1; fin_code = FLT_PAGE;
        end else if (is_ptr) begin
          if (!lvl_q) begin
            fin = 1'b1; fin_code = FLT_PAGE;
          end else begin
            go_down = 1'b1; nxt = S_RD;
          end
        end else if (leaf_fault) begin
          fin = 1'b1; fin_code = FLT_PAGE;
        end else if (need_upd) begin
          nxt = S_CAS;
        end else begin
          fin = 1'b1;
        end
      end
      S_CWAIT: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          fin = 1'b1; fin_code = FLT_ACCESS;
        end else if (mem_rsp_match) begin
          fin = 1'b1;
        end else begin
          nxt = S_RD;   // entry changed underneath: read it again
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (fin) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      fault     <= FLT_NONE;
      fault_acc <= '0;
      paddr     <= '0;
      va_q      <= '0;
      acc_q     <= '0;
      priv_q    <= 1'b0;
      sum_q     <= 1'b0;
      mxr_q     <= 1'b0;
      base_q    <= '0;
      lvl_q     <= 1'b0;
      pte_q     <= '0;
      upd_q     <= '0;
    end else begin
      st   <= nxt;
      done <= fin;
      if (fin) begin
        fault     <= fin_code;
        fault_acc <= acc_q;
        paddr     <= (fin_code == FLT_NONE) ? phys_addr : '0;
      end
      if (st == S_IDLE && req_valid) begin
        va_q   <= req_vaddr;
        acc_q  <= req_acc;
        priv_q <= req_priv_s;
        sum_q  <= req_sum;
        mxr_q  <= req_mxr;
        base_q <= req_root_ppn;
        lvl_q  <= 1'b1;
      end
      if (go_down) begin
        base_q <= mem_rsp_data[PPN_LSB +: PPN_W];
        lvl_q  <= 1'b0;
      end
      if (st == S_RWAIT && mem_rsp_valid) begin
        pte_q <= mem_rsp_data;
        upd_q <= chk_upd;
      end
    end
  end

  assert_busy_refuses_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_access_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (done && fault == FLT_ACCESS) |-> $past(mem_rsp_valid && mem_rsp_err));

  assert_cas_only_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |->
      ((mem_req_wdata & ~PTE_W'(8'hC0)) == (mem_req_cmp & ~PTE_W'(8'hC0))) && mem_req_wdata[BIT_A]);

  assert_offset_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (done && fault == FLT_NONE) |-> (paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_mem_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
endmodule

// File: tb/vm_walker_test.sv
`timescale 1ns/1ps
module vm_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [21:0] req_root_ppn = '0;
  logic        req_priv_s = 1'b0, req_sum = 1'b0, req_mxr = 1'b0;
  logic [1:0]  req_acc = '0;
  logic        mem_req_valid, mem_req_write;
  logic [33:0] mem_req_addr;
  logic [31:0] mem_req_cmp, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0, mem_rsp_match = 1'b0;
  logic        done;
  logic [1:0]  fault, fault_acc;
  logic [33:0] paddr;

  always #2 clk = ~clk;

  vm_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root_ppn(req_root_ppn), .req_priv_s(req_priv_s),
    .req_sum(req_sum), .req_mxr(req_mxr), .req_acc(req_acc),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_cmp(mem_req_cmp), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_match(mem_rsp_match), .done(done), .fault(fault), .fault_acc(fault_acc),
    .paddr(paddr)
  );

  int n_chk = 0, n_err = 0;
  logic [31:0] mem [0:2047];
  bit          err_en = 0, err_wr = 0;
  logic [33:0] err_addr = '0;
  int          intf_cnt = 0;
  logic [33:0] log_a [0:7];
  bit          log_w [0:7];
  int          log_n = 0, ovl = 0;
  bit          pend = 0, prev_req = 0, p_w = 0;
  logic [33:0] p_a;
  logic [31:0] p_c, p_d;

  // expected outcome of one walk
  int          e_flt, e_tag, e_nreq, e_nrd, e_idx;
  bit          e_upd;
  logic [33:0] e_pa, e_a0, e_a1;
  logic [31:0] e_new;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit bad(input logic [33:0] a, input bit wr);
    return (a[33:13] != '0) || (err_en && a == err_addr && err_wr == wr);
  endfunction

  // memory model: answers one cycle after each request
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    mem_rsp_match = 1'b0;
    if (pend) begin
      pend = 0;
      mem_rsp_valid = 1'b1;
      if (bad(p_a, p_w)) mem_rsp_err = 1'b1;
      else if (!p_w) mem_rsp_data = mem[p_a[12:2]];
      else begin
        if (intf_cnt > 0) begin
          mem[p_a[12:2]] = mem[p_a[12:2]] ^ 32'h100;
          intf_cnt--;
        end
        if (mem[p_a[12:2]] == p_c) begin
          mem[p_a[12:2]] = p_d;
          mem_rsp_match = 1'b1;
        end
      end
    end
    if (mem_req_valid) begin
      if (pend || prev_req) ovl++;
      pend = 1;
      p_a = mem_req_addr; p_w = mem_req_write; p_c = mem_req_cmp; p_d = mem_req_wdata;
      if (log_n < 8) begin
        log_a[log_n] = mem_req_addr;
        log_w[log_n] = mem_req_write;
      end
      log_n++;
    end
    prev_req = mem_req_valid;
  end

  // reference walk computed from the requirements
  task automatic ref_walk(input logic [31:0] va, input logic [21:0] root,
                          input bit pr, input bit su, input bit mx, input logic [1:0] ac);
    logic [21:0] base;
    bit          lvl, fin, ok;
    logic [31:0] p;
    logic [33:0] a;
    base = root; lvl = 1; fin = 0;
    e_flt = 0; e_tag = 10; e_pa = '0; e_nreq = 0; e_nrd = 0; e_upd = 0; e_idx = 0; e_new = '0;
    for (int s = 0; s < 2 && !fin; s++) begin
      a = {base, (lvl ? va[31:22] : va[21:12]), 2'b00};
      if (s == 0) e_a0 = a; else e_a1 = a;
      e_nreq++; e_nrd++;
      if (bad(a, 0)) begin
        e_flt = 2; e_tag = 5; fin = 1;                    // R5
      end else begin
        p = mem[a[12:2]];
        if (!p[0] || (!p[1] && p[2])) begin
          e_flt = 1; e_tag = 3; fin = 1;                  // R3
        end else if (!p[1] && !p[3]) begin
          if (!lvl) begin e_flt = 1; e_tag = 4; fin = 1; end  // R4
          else begin base = p[31:10]; lvl = 0; end
        end else begin
          fin = 1;
          ok = (ac == 0) ? (p[1] | (mx & p[3])) : (ac == 1) ? p[2] : p[3];
          if (!pr && !p[4]) ok = 0;
          if (pr && p[4] && (!su || ac == 2)) ok = 0;
          if (!ok) begin e_flt = 1; e_tag = 6; end        // R6
          else if (lvl && p[19:10] != '0) begin e_flt = 1; e_tag = 7; end  // R7
          else begin
            if (!p[6] || (ac == 1 && !p[7])) begin        // R8
              e_nreq++; e_upd = 1; e_idx = int'(a[12:2]);
              e_new = p | 32'h40 | ((ac == 1) ? 32'h80 : 32'h0);
              if (bad(a, 1)) begin e_flt = 2; e_tag = 5; e_upd = 0; end
            end
            if (e_flt == 0) e_pa = {p[31:20], (lvl ? va[21:12] : p[19:10]), va[11:0]};
          end
        end
      end
    end
  endtask

  task automatic wait_done();
    int cyc;
    cyc = 0;
    while (done !== 1'b1 && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_result(input logic [1:0] ac, input bit intf);
    chk(done === 1'b1, "R11 done pulse seen", {63'd0, done}, 1);
    chk(fault == e_flt[1:0], $sformatf("R%0d fault code", e_tag), fault, e_flt);
    chk(fault_acc == ac, "R11 access kind echoed", fault_acc, ac);
    if (e_flt == 0) chk(paddr == e_pa, "R10 physical address", paddr, e_pa);
    chk(log_n == e_nreq, "R12 request count", log_n, e_nreq);
    chk(log_a[0] == e_a0, "R2 first entry address", log_a[0], e_a0);
    if (e_nrd > 1) chk(log_a[1] == e_a1, "R2 second entry address", log_a[1], e_a1);
    if (e_upd) chk(mem[e_idx] == e_new, "R8 updated entry", mem[e_idx], e_new);
    if (intf && e_upd && log_n >= 3)
      chk(log_a[log_n-2] == log_a[log_n-3] && log_w[log_n-3] && !log_w[log_n-2],
          "R9 re-read after mismatch", log_a[log_n-2], log_a[log_n-3]);
  endtask

  task automatic walk(input logic [31:0] va, input logic [21:0] root, input bit pr,
                      input bit su, input bit mx, input logic [1:0] ac, input bit intf);
    ref_walk(va, root, pr, su, mx, ac);
    if (intf && e_upd) begin
      e_nreq += 2;
      e_new  = e_new ^ 32'h100;
      intf_cnt = 1;
    end
    @(negedge clk);
    log_n = 0;
    req_vaddr = va; req_root_ppn = root; req_priv_s = pr; req_sum = su;
    req_mxr = mx; req_acc = ac; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    check_result(ac, intf);
    intf_cnt = 0;
  endtask

  function automatic logic [31:0] mk_pte(input logic [21:0] ppn, input bit d, input bit a,
                                         input logic [4:0] bits);
    return {ppn, 2'b00, d, a, 1'b0, bits};
  endfunction

  initial begin
    int k;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(done == 1'b0, "R1 done low after reset", done, 0);
    chk(mem_req_valid == 1'b0, "R1 no memory request after reset", mem_req_valid, 0);

    // R1: request fields changing while busy are ignored
    mem[5] = mk_pte(22'd1, 0, 0, 5'b00001);
    mem[1024 + 7] = mk_pte(22'h12345, 1, 1, 5'b01111);
    ref_walk({10'd5, 10'd7, 12'hABC}, 22'd0, 1, 0, 0, 2'd0);
    log_n = 0;
    req_vaddr = {10'd5, 10'd7, 12'hABC}; req_root_ppn = '0; req_priv_s = 1;
    req_sum = 0; req_mxr = 0; req_acc = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    req_vaddr = {10'd9, 10'd3, 12'h123}; req_acc = 2'd2;
    for (int j = 0; j < 3; j++) begin
      chk(req_ready == 1'b0, "R1 not ready while busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_done();
    check_result(2'd0, 0);
    repeat (4) @(negedge clk);
    chk(log_n == e_nreq, "R1 no extra walk after busy requests", log_n, e_nreq);

    // sweep: second-level leaves, every flag and request combination
    k = 0;
    for (int bits = 0; bits < 32; bits++)
      for (int ad = 0; ad < 4; ad++)
        for (int ac = 0; ac < 3; ac++)
          for (int m = 0; m < 8; m++) begin
            logic [9:0] v1, v0;
            v1 = 10'((k * 37 + 5) % 1024);
            v0 = 10'((k * 53 + 3) % 1024);
            mem[v1] = mk_pte(22'd1, 0, 0, 5'b00001);
            mem[1024 + int'(v0)] = mk_pte(22'h2A5A5 ^ 22'(k), ad[1], ad[0], 5'(bits));
            walk({v1, v0, 12'((k * 97) % 4096)}, 22'd0, m[2], m[1], m[0], 2'(ac), 0);
            k++;
          end

    // sweep: first-level leaves (superpages), some misaligned (R7)
    for (int bits = 0; bits < 32; bits++)
      for (int ad = 0; ad < 4; ad++)
        for (int ac = 0; ac < 3; ac++)
          for (int m = 0; m < 8; m++) begin
            logic [9:0] v1;
            logic [21:0] pp;
            v1 = 10'((k * 41 + 11) % 1024);
            pp = {12'hA50 ^ 12'(k), ((k % 3) == 0) ? (10'(k) | 10'd1) : 10'd0};
            mem[v1] = mk_pte(pp, ad[1], ad[0], 5'(bits));
            walk({v1, 10'((k * 29) % 1024), 12'((k * 71) % 4096)}, 22'd0, m[2], m[1], m[0], 2'(ac), 0);
            k++;
          end

    // R5: errors on each kind of table access
    mem[20] = mk_pte(22'd1, 0, 0, 5'b00001);
    mem[1024 + 30] = mk_pte(22'h0BEEF, 0, 0, 5'b10111);
    err_en = 1; err_wr = 0; err_addr = {22'd0, 10'd20, 2'b00};
    walk({10'd20, 10'd30, 12'h010}, 22'd0, 0, 0, 0, 2'd1, 0);
    err_addr = {22'd1, 10'd30, 2'b00};
    walk({10'd20, 10'd30, 12'h010}, 22'd0, 0, 0, 0, 2'd1, 0);
    err_wr = 1;
    walk({10'd20, 10'd30, 12'h010}, 22'd0, 0, 0, 0, 2'd1, 0);
    err_en = 0;

    // R9: entry changed between read and compare-and-write
    mem[1024 + 30] = mk_pte(22'h0BEEF, 0, 0, 5'b10111);
    walk({10'd20, 10'd30, 12'h010}, 22'd0, 0, 0, 0, 2'd1, 1);
    mem[40] = mk_pte(22'h3C000, 0, 0, 5'b00011);
    walk({10'd40, 10'd77, 12'h5A5}, 22'd0, 1, 0, 0, 2'd0, 1);

    chk(ovl == 0, "R12 single outstanding request", ovl, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule